// File: doc/BRIEF.md
# Stream-Fed Piecewise-Linear Function Generator

This block evaluates one-variable piecewise-linear functions beside a main processor, with no instructions from it. A read-only store delivers 11-bit words at a fixed rate, one valid strobe per word. The block does not address that store. It watches the word sequence and acts on words according to their position in a function block.

A control word opens a function block. The next words name the working-memory address of the independent variable X. Nine ordinates follow, then two blank words, then the address that receives the result. The block fetches X and writes the result through a request/grant port to the shared working memory. It retries on each repeated address word until the arbiter grants it.

The unit interval of X is cut into eight equal segments. The block keeps only the two ordinates that bound the segment holding X. It interpolates between them to 14 bits with rounding. It then writes the result back as a 24-bit sign-magnitude word.

Top module: `interp_top`

## Requirements
- R1: After reset, memReq and missedAccess are low.
- R2: A word with bit 10 set is a control word. It starts a new function block at any time and abandons any block in progress. The block layout is: the control word, ADDR_REPS X-address words, nine ordinates f(0)..f(8), two blank words, and RES_REPS result-address words.
- R3: During the valid cycle of each X-address word, the block raises memReq with memWe low and memAddr equal to word bits [9:0]. It does this only until one request is granted. Later repeats in that phase issue no request.
- R4: In the fetched 24-bit X word, bits [22:20] give the segment k. Bits [19:9] give the fraction r as a value over 2048. Bit 23 (sign) and bits [8:0] have no effect on the result.
- R5: Only ordinates k and k+1 affect the result. The other seven are discarded.
- R6: The 14-bit result is floor((16*f_k*2048 + 16*(f_{k+1}-f_k)*r + 1024) / 2048), that is, 16*(f_k + (f_{k+1}-f_k)*r/2048) rounded half up.
- R7: During each result-address word, the block raises memReq with memWe high and memAddr equal to word bits [9:0] until one write is granted. The write data is {1'b0, result[13:0], 9'b0}. Exactly one write is granted per function.
- R8: If none of the X-address requests is granted, the block skips the function. It issues no write and sets missedAccess.
- R9: If none of the result-address requests is granted, the block sets missedAccess.
- R10: Once set, missedAccess stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | One-cycle strobe marking a new stream word |
| wordData | input | 11 | Stream word: bit 10 is the control flag, bits [9:0] are data |
| memGnt | input | 1 | Arbiter grant for the current request |
| memRdata | input | 24 | Read data from working memory, valid in the granted cycle |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | High for a write request, low for a read request |
| memAddr | output | 10 | Working-memory address |
| memWdata | output | 24 | Result word to write |
| missedAccess | output | 1 | Sticky flag: a memory phase got no grant |

## Verification
On every cycle, the assertions check four things:
- requests appear only on word strobes;
- ordinates are collected only after X was fetched;
- a written word has a clear sign bit;
- the interpolated value lies between the two kept ordinates, and the missed-access flag never falls.

The bench's scenarios show the behaviour that needs the whole stream:
- the exact rounded value over a sweep of every segment, several fractions and several ordinate shapes;
- late grants and the request count per phase;
- resynchronisation on a control word;
- skipped functions and missed writes.

// File: rtl/interp_pkg.sv
package interp_pkg;
  localparam int SEG_BITS = 3;
  localparam int ORD_W    = 10;
  localparam int ACC_W    = 14;
  localparam int MEM_W    = 24;
  localparam int NUM_ORD  = (1 << SEG_BITS) + 1;
  localparam int IDX_W    = $clog2(NUM_ORD);
  localparam int FRAC_W   = ACC_W - SEG_BITS;

  typedef struct packed {
    logic             xLatch;
    logic             ordValid;
    logic [IDX_W-1:0] ordIdx;
  } strobe_t;
endpackage

// File: rtl/interp_ctrl.sv
module interp_ctrl
  import interp_pkg::*;
#(
  parameter int ADDR_REPS = 4,
  parameter int RES_REPS  = 4,
  parameter int BLANKS    = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wordValid,
  input  logic    isCtrl,
  input  logic    memGnt,
  output logic    memReq,
  output logic    memWe,
  output strobe_t strobes,
  output logic    missedAccess
);
  localparam int MAXC  = (ADDR_REPS > RES_REPS) ?
                         ((ADDR_REPS > NUM_ORD) ? ADDR_REPS : NUM_ORD) :
                         ((RES_REPS > NUM_ORD) ? RES_REPS : NUM_ORD);
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_XADDR, S_ORD, S_BLANK, S_RADDR} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             granted;
  logic             dataWord;
  logic             gntNow;

  assign dataWord = wordValid && !isCtrl;
  assign memReq   = dataWord && !granted && (state == S_XADDR || state == S_RADDR);
  assign memWe    = (state == S_RADDR);
  assign gntNow   = memReq && memGnt;

  assign strobes.xLatch   = gntNow && (state == S_XADDR);
  assign strobes.ordValid = dataWord && (state == S_ORD);
  assign strobes.ordIdx   = cnt[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      cnt          <= '0;
      granted      <= 1'b0;
      missedAccess <= 1'b0;
    end else if (wordValid) begin
      if (isCtrl) begin
        state   <= S_XADDR;
        cnt     <= '0;
        granted <= 1'b0;
      end else begin
        case (state)
          S_XADDR: begin
            if (gntNow) granted <= 1'b1;
            if (cnt == CNT_W'(ADDR_REPS - 1)) begin
              cnt <= '0;
              if (granted || gntNow) begin
                state <= S_ORD;
              end else begin
                state        <= S_IDLE;
                missedAccess <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ORD: begin
            if (cnt == CNT_W'(NUM_ORD - 1)) begin
              state <= S_BLANK;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_BLANK: begin
            if (cnt == CNT_W'(BLANKS - 1)) begin
              state   <= S_RADDR;
              cnt     <= '0;
              granted <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RADDR: begin
            if (gntNow) granted <= 1'b1;
            if (cnt == CNT_W'(RES_REPS - 1)) begin
              state <= S_IDLE;
              cnt   <= '0;
              if (!(granted || gntNow)) missedAccess <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            state <= S_IDLE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end

  // R5: ordinates are only collected once X has been fetched
  assert_ord_after_grant_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ORD) |-> granted);

  // R10: the missed-access flag never falls outside reset
  assert_sticky_miss_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(missedAccess) |-> missedAccess);
endmodule

// File: rtl/interp_datapath.sv
module interp_datapath
  import interp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [ORD_W-1:0] ordData,
  input  logic [MEM_W-1:0] memRdata,
  output logic [MEM_W-1:0] memWdata
);
  localparam int PROD_W = ORD_W + FRAC_W + 2;
  localparam int SHIFT  = FRAC_W - (ACC_W - ORD_W);
  localparam int PAD_W  = MEM_W - 1 - ACC_W;
  localparam int SEG_HI = MEM_W - 2;
  localparam int FR_HI  = SEG_HI - SEG_BITS;
  localparam logic signed [PROD_W-1:0] ROUND_K = PROD_W'(1) <<< (SHIFT - 1);

  logic [SEG_BITS-1:0] seg;
  logic [FRAC_W-1:0]   frac;
  logic [ORD_W-1:0]    fLo, fHi;
  logic [IDX_W-1:0]    loIdx, hiIdx;

  logic signed [ORD_W:0]    diff;
  logic signed [PROD_W-1:0] prod, rounded, sum;
  logic [ACC_W-1:0]         result;
  logic                     unusedXbits;

  assign unusedXbits = ^{memRdata[MEM_W-1], memRdata[FR_HI-FRAC_W:0]};

  assign loIdx = IDX_W'(seg);
  assign hiIdx = IDX_W'(seg) + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seg  <= '0;
      frac <= '0;
      fLo  <= '0;
      fHi  <= '0;
    end else begin
      if (strobes.xLatch) begin
        seg  <= memRdata[SEG_HI -: SEG_BITS];
        frac <= memRdata[FR_HI -: FRAC_W];
      end
      if (strobes.ordValid && strobes.ordIdx == loIdx) fLo <= ordData;
      if (strobes.ordValid && strobes.ordIdx == hiIdx) fHi <= ordData;
    end
  end

  always_comb begin
    diff    = $signed({1'b0, fHi}) - $signed({1'b0, fLo});
    prod    = PROD_W'(diff) * $signed({1'b0, frac});
    rounded = (prod + ROUND_K) >>> SHIFT;
    sum     = $signed({{(PROD_W - ACC_W){1'b0}}, fLo, {(ACC_W - ORD_W){1'b0}}}) + rounded;
    result  = sum[ACC_W-1:0];
  end

  assign memWdata = {1'b0, result, {PAD_W{1'b0}}};

  // R6: the interpolated value stays between the two kept ordinates
  assert_result_bounded_R6: assert property (@(posedge clk) disable iff (!rstN)
    (result >= ((fLo < fHi) ? {fLo, 4'b0} : {fHi, 4'b0})) &&
    (result <= ((fLo < fHi) ? {fHi, 4'b0} : {fLo, 4'b0})));
endmodule

// File: rtl/interp_top.sv
module interp_top
  import interp_pkg::*;
#(
  parameter int ADDR_REPS = 4,
  parameter int RES_REPS  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wordValid,
  input  logic [ORD_W:0]   wordData,
  input  logic             memGnt,
  input  logic [MEM_W-1:0] memRdata,
  output logic             memReq,
  output logic             memWe,
  output logic [ORD_W-1:0] memAddr,
  output logic [MEM_W-1:0] memWdata,
  output logic             missedAccess
);
  strobe_t strobes;

  assign memAddr = wordData[ORD_W-1:0];

  interp_ctrl #(
    .ADDR_REPS(ADDR_REPS),
    .RES_REPS (RES_REPS),
    .BLANKS   (2)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wordValid   (wordValid),
    .isCtrl      (wordData[ORD_W]),
    .memGnt      (memGnt),
    .memReq      (memReq),
    .memWe       (memWe),
    .strobes     (strobes),
    .missedAccess(missedAccess)
  );

  interp_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .ordData (wordData[ORD_W-1:0]),
    .memRdata(memRdata),
    .memWdata(memWdata)
  );

  // R3: requests only ever accompany a stream word strobe
  assert_req_on_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> wordValid);

  // R7: a write never carries a set sign bit
  assert_write_sign_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> !memWdata[MEM_W-1]);
endmodule

// File: tb/test_interp_top.sv
module test_interp_top;
  localparam int AREPS = 4;
  localparam int RREPS = 4;
  localparam int GAP   = 4;
  localparam logic [23:0] SENT = 24'hA5A5A5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [10:0] wordData = '0;
  logic        memGnt;
  logic [23:0] memRdata;
  logic        memReq, memWe, missedAccess;
  logic [9:0]  memAddr;
  logic [23:0] memWdata;
  logic        allow = 1'b1;

  logic [23:0] mem [0:1023];
  int ords [0:8];
  int checks = 0, errors = 0;
  int readReqs = 0, readGnts = 0, writeReqs = 0, writeGnts = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  interp_top #(.ADDR_REPS(AREPS), .RES_REPS(RREPS)) i_interp_top (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .memGnt(memGnt), .memRdata(memRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .missedAccess(missedAccess));

  assign memGnt   = memReq & allow;
  assign memRdata = mem[memAddr];

  always @(posedge clk) begin
    if (memReq && !memWe) readReqs <= readReqs + 1;
    if (memReq && memGnt && !memWe) readGnts <= readGnts + 1;
    if (memReq && memWe) writeReqs <= writeReqs + 1;
    if (memReq && memGnt && memWe) begin
      writeGnts <= writeGnts + 1;
      mem[memAddr] <= memWdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] expWord(input logic [23:0] x);
    int k, r, num, e;
    k   = int'(x[22:20]);
    r   = int'(x[19:9]);
    num = ords[k] * 32768 + (ords[k+1] - ords[k]) * r * 16 + 1024;
    e   = num / 2048;
    return {1'b0, 14'(e), 9'b0};
  endfunction

  task automatic sendWord(input bit ctrl, input logic [9:0] d, input bit alw);
    @(negedge clk);
    allow     = alw;
    wordValid = 1'b1;
    wordData  = {ctrl, d};
    @(negedge clk);
    wordValid = 1'b0;
    allow     = 1'b1;
    repeat (GAP - 1) @(negedge clk);
  endtask

  task automatic clearCounts();
    @(negedge clk);
    readReqs = 0; readGnts = 0; writeReqs = 0; writeGnts = 0;
  endtask

  task automatic sendFunction(input logic [9:0] xA, input logic [9:0] rA,
                              input int denyX, input int denyR);
    sendWord(1'b1, 10'h0, 1'b1);
    for (int i = 0; i < AREPS; i++) sendWord(1'b0, xA, i >= denyX);
    for (int i = 0; i < 9; i++) sendWord(1'b0, 10'(ords[i]), 1'b1);
    for (int i = 0; i < 2; i++) sendWord(1'b0, 10'h0, 1'b1);
    for (int i = 0; i < RREPS; i++) sendWord(1'b0, rA, i >= denyR);
    repeat (3) @(negedge clk);
  endtask

  task automatic fillOrds(input int pat, input int seg);
    for (int i = 0; i < 9; i++) begin
      case (pat)
        0: ords[i] = i * 127;
        1: ords[i] = 1023 - i * 120;
        default: ords[i] = (i * 379 + 57 * seg + pat * 11) % 1024;
      endcase
    end
  endtask

  task automatic runCase(input int seg, input int r, input bit sgn,
                         input int n, input int denyX, input int denyR);
    logic [9:0] xA, rA;
    logic [23:0] x, e;
    xA = 10'(32'h100 + n % 64);
    rA = 10'(32'h200 + n % 64);
    x = {sgn, 3'(seg), 11'(r), 9'h0AB};
    mem[xA] = x;
    mem[rA] = SENT;
    e = expWord(x);
    clearCounts();
    sendFunction(xA, rA, denyX, denyR);
    chk(mem[rA] == e, "R6", "result word", int'(mem[rA]), int'(e));
    chk(readReqs == denyX + 1 && readGnts == 1, "R3", "read requests",
        readReqs, denyX + 1);
    chk(writeReqs == denyR + 1 && writeGnts == 1, "R7", "write grants",
        writeGnts, 1);
  endtask

  initial begin
    int fr [4];
    logic [23:0] ref0;
    for (int i = 0; i < 1024; i++) mem[i] = 24'h0;
    repeat (3) @(negedge clk);
    chk(memReq == 1'b0, "R1", "memReq after reset", int'(memReq), 0);
    chk(missedAccess == 1'b0, "R1", "missedAccess after reset", int'(missedAccess), 0);
    rstN = 1'b1;

    // R4 R5 R6 R7: sweep every segment, fraction corners and ordinate shapes
    for (int seg = 0; seg < 8; seg++) begin
      fr[0] = 0; fr[1] = 2047; fr[2] = 1024; fr[3] = 333 + seg * 100;
      for (int p = 0; p < 3; p++) begin
        for (int f = 0; f < 4; f++) begin
          fillOrds(p, seg);
          runCase(seg, fr[f], 1'b0, seg * 12 + p * 4 + f, 0, 0);
        end
      end
    end

    // R4: sign bit and low bits of X have no effect
    fillOrds(2, 5);
    runCase(5, 777, 1'b1, 3, 0, 0);

    // R5: changing the discarded ordinates leaves the result unchanged
    fillOrds(0, 0);
    runCase(3, 1500, 1'b0, 7, 0, 0);
    ref0 = mem[10'h207];
    for (int i = 0; i < 9; i++) if (i != 3 && i != 4) ords[i] = 1023 - ords[i];
    runCase(3, 1500, 1'b0, 7, 0, 0);
    chk(mem[10'h207] == ref0, "R5", "result with other ordinates changed",
        int'(mem[10'h207]), int'(ref0));

    // R3 R7: grants arriving on the last repeat
    fillOrds(1, 0);
    runCase(6, 900, 1'b0, 20, AREPS - 1, RREPS - 1);
    runCase(2, 1, 1'b0, 21, 1, 2);
    chk(missedAccess == 1'b0, "R8", "no miss after granted functions",
        int'(missedAccess), 0);

    // R2: a control word abandons a block in progress
    fillOrds(2, 1);
    mem[10'h150] = {1'b0, 3'd7, 11'd2000, 9'h0};
    mem[10'h250] = SENT;
    clearCounts();
    sendWord(1'b1, 10'h0, 1'b1);
    sendWord(1'b0, 10'h150, 1'b1);
    sendWord(1'b0, 10'h150, 1'b1);
    sendWord(1'b0, 10'h0, 1'b1);
    runCase(1, 600, 1'b0, 22, 0, 0);
    chk(mem[10'h250] == SENT, "R2", "abandoned block wrote nothing",
        int'(mem[10'h250]), int'(SENT));

    // R8: no grant on any X repeat skips the function
    mem[10'h130] = {1'b0, 3'd4, 11'd100, 9'h0};
    mem[10'h230] = SENT;
    clearCounts();
    sendFunction(10'h130, 10'h230, AREPS, 0);
    chk(mem[10'h230] == SENT, "R8", "skipped function target", int'(mem[10'h230]), int'(SENT));
    chk(writeReqs == 0, "R8", "write requests on skip", writeReqs, 0);
    chk(missedAccess == 1'b1, "R8", "missedAccess after X miss", int'(missedAccess), 1);

    // R10: flag stays set across a later good function
    fillOrds(0, 0);
    runCase(4, 1234, 1'b0, 31, 0, 0);
    chk(missedAccess == 1'b1, "R10", "missedAccess still set", int'(missedAccess), 1);

    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(missedAccess == 1'b0, "R10", "missedAccess cleared by reset", int'(missedAccess), 0);
    rstN = 1'b1;

    // R9: no grant on any result repeat
    mem[10'h131] = {1'b0, 3'd2, 11'd50, 9'h0};
    mem[10'h231] = SENT;
    clearCounts();
    sendFunction(10'h131, 10'h231, 0, RREPS);
    chk(mem[10'h231] == SENT, "R9", "missed write target", int'(mem[10'h231]), int'(SENT));
    chk(missedAccess == 1'b1, "R9", "missedAccess after write miss", int'(missedAccess), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule